// File: doc/BRIEF.md
# Dual-modulus PLL feedback divider

This block is the digital divider chain of an integer-N frequency synthesizer. The oscillator-derived input arrives as a one-cycle tick strobe in the fast system clock domain. It passes through a fixed divide-by-2 stage and then through a prescaler whose modulus is 32 or 33. A swallow counter and a main counter choose the modulus, so that one comparison pulse is produced every 2·N input ticks. The oscillator therefore settles at fosc = 2·fr·N. The 15-bit ratio N is split into a swallow count (its five low bits) and a main count (its ten high bits). A new ratio takes effect only at the end of a division period, so no period is ever cut short or stretched.

A second chain divides crystal ticks down to the comparison reference, at a ratio of 128 or 64 chosen by one select input. With a 4 MHz crystal that gives a 31.25 kHz or 62.5 kHz reference, and a synthesizer step of 62.5 kHz or 125 kHz. A two-bit test select routes one internal signal to a single test output so the chain can be probed on silicon. The analog prescaler front end that makes the ticks sits outside this block.

Top module: `pll_fb_divider`

## Requirements
- R1: While `rst_n` is low, `fb_pulse`, `ref_pulse` and `test_out` are low, and the divide-by-2 stage output is low. The division counters restart from zero when reset is released.
- R2: For an applied ratio N in 1024..32767, `fb_pulse` is high for the one cycle after the clock edge that consumes the 2·N-th `vco_tick` of the period. The tick rate may be anything up to one per cycle.
- R3: The ratio is split into swallow count A = N[4:0] and main count M = N[14:5]. The prescaler divides by 33 for A of its cycles and by 32 for the other M−A cycles. The period stays exactly 2·N ticks at both extremes of A, 0 and 31.
- R4: A ratio below 1024 is replaced by 1024 when it is adopted, so the period is 2048 ticks.
- R5: `n_ratio` is sampled at the clock edge that ends a period, and also during reset. A change made part-way through a period does not alter that period.
- R6: `fb_pulse` and `ref_pulse` are each high for exactly one cycle per period.
- R7: `ref_pulse` occurs once every 128 `xtal_tick`s when the applied `ref_fast` is 0, and once every 64 when it is 1. `ref_fast` is sampled at the edge ending a reference period, and also during reset.
- R8: `test_out` follows `test_sel` with no added delay: 2'b00 gives constant 0, 2'b01 gives `ref_pulse`, 2'b10 gives the divide-by-2 stage output, and 2'b11 gives `fb_pulse`. The divide-by-2 output toggles on every accepted `vco_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One-cycle strobe per oscillator-derived input edge |
| xtal_tick | input | 1 | One-cycle strobe per crystal edge |
| n_ratio | input | 15 | Requested division ratio N |
| ref_fast | input | 1 | Reference ratio select: 0 gives 128, 1 gives 64 |
| test_sel | input | 2 | Test output source select |
| fb_pulse | output | 1 | Divided-oscillator comparison pulse |
| ref_pulse | output | 1 | Reference comparison pulse |
| test_out | output | 1 | Selected internal signal |

## Verification
The two comparison pulses come from independent chains and can fall in the same cycle. Running both tick strobes every cycle with N = 1024 and the 64 reference ratio makes the 2048-tick feedback period a multiple of the reference period, so the pulses coincide at cycle 2048. Each pulse is then judged by its own scoreboard against its own expected tick count. The test output is compared every cycle, so in the reference-tap setting a coincident pulse must still show up on it. Ratio changes are made just after a period starts, and the period in flight must keep the old length.

// File: rtl/pfd_pkg.sv
// Shared definitions for the PLL feedback divider.
// Assumes: test select encodings are fixed by the external probe flow.
package pfd_pkg;

    // Source routed to the test output
    typedef enum logic [1:0] {
        TST_OFF  = 2'b00,
        TST_REF  = 2'b01,
        TST_HALF = 2'b10,
        TST_FB   = 2'b11
    } tst_sel_e;

endpackage

// File: rtl/pfd_half_stage.sv
// Fixed divide-by-2 stage on the oscillator tick stream.
// half_q toggles on every input tick. half_tick marks every second tick,
// the one that returns half_q to zero.
// Assumes: tick_in is a single-cycle strobe in the clk domain.
module pfd_half_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic half_q,
    output logic half_tick
);

    // Toggle flop for the divide-by-2 state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (tick_in) begin
            half_q <= ~half_q;
        end
    end

    assign half_tick = tick_in & half_q;

endmodule

// File: rtl/pfd_prescaler.sv
// Dual-modulus prescaler: divides the half-rate tick stream by LOW or LOW+1.
// out_tick marks the input tick that closes a prescaler cycle.
// Assumes: mod_hi only changes on a clock edge where out_tick was high.
module pfd_prescaler #(
    parameter int LOW = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    input  logic mod_hi,
    output logic out_tick
);

    localparam int CW = $clog2(LOW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_val;

    assign last_val = mod_hi ? CW'(LOW) : CW'(LOW - 1);
    assign out_tick = in_tick && (cnt == last_val);

    // Position within the current prescaler cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (in_tick) begin
            cnt <= out_tick ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pfd_swallow.sv
// Swallow and main counters that steer the prescaler modulus.
// The low A_W bits of the ratio give the swallow count A and the rest give
// the main count M. The prescaler runs at high modulus for the first A of
// the M prescaler cycles. The ratio is adopted at period end and clamped to
// MIN_N.
// Assumes: MIN_N >> A_W is at least 2**A_W, so that A < M always holds.
module pfd_swallow #(
    parameter int N_W   = 15,
    parameter int A_W   = 5,
    parameter int MIN_N = 1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tick,
    input  logic [N_W-1:0] n_req,
    output logic           mod_hi,
    output logic           period_end
);

    localparam int M_W = N_W - A_W;

    logic [N_W-1:0] n_eff;
    logic [A_W-1:0] a_cur;
    logic [M_W-1:0] m_cur;
    logic [M_W-1:0] cyc;
    logic           last_cyc;
    logic           wrap;

    assign n_eff    = (n_req < N_W'(MIN_N)) ? N_W'(MIN_N) : n_req;
    assign last_cyc = (cyc == m_cur - M_W'(1));
    assign wrap     = pre_tick && last_cyc;
    assign mod_hi   = (M_W'(a_cur) > cyc);

    // Prescaler-cycle counter, ratio adoption and period-end pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cur      <= n_eff[A_W-1:0];
            m_cur      <= n_eff[N_W-1:A_W];
            cyc        <= '0;
            period_end <= 1'b0;
        end else begin
            period_end <= wrap;
            if (pre_tick) begin
                if (last_cyc) begin
                    cyc   <= '0;
                    a_cur <= n_eff[A_W-1:0];
                    m_cur <= n_eff[N_W-1:A_W];
                end else begin
                    cyc <= cyc + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pfd_ref_div.sv
// Reference divider: turns crystal ticks into one pulse per SLOW or FAST
// ticks. The select is adopted at the end of each reference period.
// Assumes: SLOW > FAST > 1 and SLOW is a power of two.
module pfd_ref_div #(
    parameter int SLOW = 128,
    parameter int FAST = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic fast_sel,
    output logic ref_pulse
);

    localparam int RW = $clog2(SLOW);

    logic [RW-1:0] cnt;
    logic          fast_q;
    logic          wrap;

    assign wrap = xtal_tick && (cnt == (fast_q ? RW'(FAST - 1) : RW'(SLOW - 1)));

    // Reference count, ratio adoption and output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            fast_q    <= fast_sel;
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= wrap;
            if (xtal_tick) begin
                if (wrap) begin
                    cnt    <= '0;
                    fast_q <= fast_sel;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pll_fb_divider.sv
// Top of the PLL feedback divider: divide-by-2, dual-modulus prescaler,
// swallow/main counters, reference divider and test multiplexer.
// Assumes: vco_tick and xtal_tick are synchronous single-cycle strobes.
module pll_fb_divider #(
    parameter int N_W      = 15,
    parameter int MIN_N    = 1024,
    parameter int PRE_LOW  = 32,
    parameter int REF_SLOW = 128,
    parameter int REF_FAST = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           xtal_tick,
    input  logic [N_W-1:0] n_ratio,
    input  logic           ref_fast,
    input  logic [1:0]     test_sel,
    output logic           fb_pulse,
    output logic           ref_pulse,
    output logic           test_out
);

    import pfd_pkg::*;

    localparam int A_W = $clog2(PRE_LOW);

    logic half_q;
    logic half_tick;
    logic pre_tick;
    logic mod_hi;

    pfd_half_stage u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (vco_tick),
        .half_q    (half_q),
        .half_tick (half_tick)
    );

    pfd_prescaler #(.LOW(PRE_LOW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (half_tick),
        .mod_hi   (mod_hi),
        .out_tick (pre_tick)
    );

    pfd_swallow #(.N_W(N_W), .A_W(A_W), .MIN_N(MIN_N)) u_swal (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_tick   (pre_tick),
        .n_req      (n_ratio),
        .mod_hi     (mod_hi),
        .period_end (fb_pulse)
    );

    pfd_ref_div #(.SLOW(REF_SLOW), .FAST(REF_FAST)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .fast_sel  (ref_fast),
        .ref_pulse (ref_pulse)
    );

    // Test output source selection
    always_comb begin
        case (tst_sel_e'(test_sel))
            TST_REF:  test_out = ref_pulse;
            TST_HALF: test_out = half_q;
            TST_FB:   test_out = fb_pulse;
            default:  test_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfd_checker.sv
// Property checker for the PLL feedback divider, attached by bind.
// Tick counters measure the spacing between the pulses at the ports.
module pfd_checker #(
    parameter int MIN_N    = 1024,
    parameter int REF_SLOW = 128,
    parameter int REF_FAST = 64,
    parameter int CNT_W    = 18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vco_tick,
    input logic       xtal_tick,
    input logic [1:0] test_sel,
    input logic       fb_pulse,
    input logic       ref_pulse,
    input logic       test_out
);

    logic [CNT_W-1:0] tcnt;
    logic [CNT_W-1:0] xcnt;

    // Oscillator ticks since the last feedback pulse
    always_ff @(posedge clk) begin
        if (!rst_n)        tcnt <= '0;
        else if (fb_pulse) tcnt <= vco_tick ? CNT_W'(1) : '0;
        else if (vco_tick) tcnt <= tcnt + 1'b1;
    end

    // Crystal ticks since the last reference pulse
    always_ff @(posedge clk) begin
        if (!rst_n)         xcnt <= '0;
        else if (ref_pulse) xcnt <= xtal_tick ? CNT_W'(1) : '0;
        else if (xtal_tick) xcnt <= xcnt + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!fb_pulse && !ref_pulse)); // R1

    AST_FB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(vco_tick)); // R2

    AST_FB_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> (tcnt >= CNT_W'(2 * MIN_N))); // R4

    AST_FB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse); // R6

    AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse); // R6

    AST_REF_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> (xcnt == CNT_W'(REF_SLOW) || xcnt == CNT_W'(REF_FAST))); // R7

    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vco_tick) && test_sel == 2'b10 && $past(test_sel) == 2'b10)
        |-> (test_out != $past(test_out))); // R8

endmodule

bind pll_fb_divider pfd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vco_tick  (vco_tick),
    .xtal_tick (xtal_tick),
    .test_sel  (test_sel),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse),
    .test_out  (test_out)
);

// File: tb/pll_fb_divider_tb.sv
// Scoreboard bench: driver tasks queue expected period lengths in ticks,
// a monitor counts the ticks between pulses and compares.
module pll_fb_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        vco_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic [14:0] n_ratio;
    logic        ref_fast;
    logic [1:0]  test_sel;
    logic        fb_pulse;
    logic        ref_pulse;
    logic        test_out;

    int    total = 0;
    int    bad = 0;
    int    exp_fb[$];
    string tag_fb[$];
    int    exp_ref[$];
    bit    run = 1'b0;
    bit    done = 1'b0;
    int    vgap = 1;
    int    xgap = 1;
    int    gcnt = 0;
    int    vt = 0;
    int    xt = 0;
    int    tot_v = 0;
    int    bench_n;
    int    bench_fast;
    int    e_per;
    string e_tag;
    logic  e_tst;
    logic  fb_prev = 1'b0;
    logic  ref_prev = 1'b0;

    always #4 clk = ~clk;

    pll_fb_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vco_tick  (vco_tick),
        .xtal_tick (xtal_tick),
        .n_ratio   (n_ratio),
        .ref_fast  (ref_fast),
        .test_sel  (test_sel),
        .fb_pulse  (fb_pulse),
        .ref_pulse (ref_pulse),
        .test_out  (test_out)
    );

    function automatic int eff_n(int n);
        return (n < 1024) ? 1024 : n;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Tick generator: strobes on the falling edge
    always @(negedge clk) begin
        if (run) begin
            gcnt++;
            vco_tick  <= (vgap != 0) && (gcnt % vgap == 0);
            xtal_tick <= (xgap != 0) && (gcnt % xgap == 0);
        end
    end

    // Monitor: counts ticks consumed at each edge, pops expectations on pulses
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (vco_tick) begin vt++; tot_v++; end
            if (xtal_tick) xt++;
            case (test_sel)
                2'b00:   e_tst = 1'b0;
                2'b01:   e_tst = ref_pulse;
                2'b10:   e_tst = tot_v[0];
                default: e_tst = fb_pulse;
            endcase
            chk(test_out === e_tst, "R8", "test output", int'(test_out), int'(e_tst));
            if (fb_pulse) begin
                chk(!fb_prev, "R6", "fb pulse width", int'(fb_prev) + 1, 1);
                if (exp_fb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected fb pulse after ticks", vt, 0);
                end else begin
                    e_per = exp_fb.pop_front();
                    e_tag = tag_fb.pop_front();
                    chk(vt == e_per, e_tag, "fb period ticks", vt, e_per);
                end
                vt = 0;
            end
            if (ref_pulse) begin
                chk(!ref_prev, "R6", "ref pulse width", int'(ref_prev) + 1, 1);
                if (exp_ref.size() == 0) begin
                    chk(1'b0, "R7", "unexpected ref pulse after ticks", xt, 0);
                end else begin
                    e_per = exp_ref.pop_front();
                    chk(xt == e_per, "R7", "ref period ticks", xt, e_per);
                end
                xt = 0;
            end
            fb_prev  = fb_pulse;
            ref_prev = ref_pulse;
        end
    end

    // Driver: in-flight period keeps the old ratio, then k periods of the new
    task automatic run_fb(int newn, int k, int gap, string tag);
        exp_fb.push_back(2 * eff_n(bench_n));
        tag_fb.push_back("R5");
        for (int i = 0; i < k; i++) begin
            exp_fb.push_back(2 * eff_n(newn));
            tag_fb.push_back(tag);
        end
        @(negedge clk);
        n_ratio = 15'(newn);
        vgap = gap;
        wait (exp_fb.size() == 0);
        bench_n = newn;
    endtask

    task automatic run_ref(int fast, int k, int gap);
        exp_ref.push_back(bench_fast != 0 ? 64 : 128);
        for (int i = 0; i < k; i++) exp_ref.push_back(fast != 0 ? 64 : 128);
        @(negedge clk);
        ref_fast = fast[0];
        xgap = gap;
        wait (exp_ref.size() == 0);
        bench_fast = fast;
    endtask

    initial begin
        rst_n    = 1'b0;
        n_ratio  = 15'd1024;
        ref_fast = 1'b1;
        test_sel = 2'b10;
        run      = 1'b1;
        bench_n    = 1024;
        bench_fast = 1;
        repeat (5) @(posedge clk);
        #1;
        chk(fb_pulse == 1'b0, "R1", "fb_pulse in reset", int'(fb_pulse), 0);
        chk(ref_pulse == 1'b0, "R1", "ref_pulse in reset", int'(ref_pulse), 0);
        chk(test_out == 1'b0, "R1", "divide-by-2 output in reset", int'(test_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                run_fb(1024, 2, 1, "R2");          // A = 0, both chains coincide
                @(negedge clk) test_sel = 2'b01;
                run_fb(1055, 2, 1, "R3");          // A = 31, M = 32
                @(negedge clk) test_sel = 2'b11;
                run_fb(3000, 2, 2, "R2");          // sparse ticks
                @(negedge clk) test_sel = 2'b00;
                run_fb(100, 2, 1, "R4");           // below minimum
                @(negedge clk) test_sel = 2'b10;
                run_fb(32767, 1, 1, "R2");         // largest ratio
            end
            begin
                run_ref(1, 40, 1);
                run_ref(0, 5, 1);
                run_ref(1, 4, 3);
                run_ref(0, 3, 2);
                @(negedge clk) xgap = 0;
            end
        join
        finish_up();
    end

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        chk(1'b0, "R2", "watchdog expired, pending fb periods", exp_fb.size(), 0);
        finish_up();
    end

endmodule